// File: doc/BRIEF.md
# Repeated String-Operation Sequencer

This block runs block memory operations over arrays of bytes or 16-bit words without any per-element instruction fetch. A caller presents an operation code, an element size, a direction and a repeat mode, together with initial values for the count, source index, destination index, accumulator and the two segment bases, and pulses `start`. The sequencer then walks the arrays, issuing one memory access at a time on a request/acknowledge port, stepping the indices, counting down and updating the equality flag, until the count runs out or a comparison ends the loop.

Five operations are supported: move (copy a source element to the destination), load (source element into the accumulator), store (accumulator to the destination), scan (accumulator against a destination element) and compare (source element against destination element). The source side is addressed through the data-segment base and source index; the destination side through the extra-segment base and destination index. An interrupt request is sampled between elements. When it is honoured the sequencer parks with `paused` high, and the current count and index values, visible on the outputs, form the resume state. A `resume` pulse restarts the loop from that state.

The controller is a state machine with eight states. IDLE waits for `start`, which loads all registers and moves to LAUNCH. LAUNCH goes to DONE if a repeat mode is set and the count is zero. Otherwise it goes to the first access of the operation: RD_SRC for move, load and compare, WRITE for store, or RD_DST for scan. When acknowledged, RD_SRC goes to WRITE for move, to RD_DST for compare, or to STEP for load. RD_DST and WRITE go to STEP when acknowledged. STEP updates the indices, count and flag, then goes to one of three places. It goes to DONE if the operation was not repeated, if the count reaches zero, or if the comparison ends the loop. It goes to PAUSE if an interrupt is pending. Otherwise it goes back to the first access of the next element. PAUSE goes to LAUNCH on `resume`. DONE returns to IDLE after one cycle.

Top module: `strop_engine`

## Requirements
- R1: The source physical address is the data-segment base times 16 plus the source index, and the destination address is the extra-segment base times 16 plus the destination index, both taken modulo 2^20.
- R2: A move (op code 0) makes exactly one read from the source and one write to the destination per element and copies the element unchanged, for bytes (`wide_i`=0) and words (`wide_i`=1).
- R3: A load (op code 1) reads the source element into the accumulator without writing memory. A byte load replaces only accumulator bits 7:0 and keeps bits 15:8.
- R4: A store (op code 2) writes the accumulator (bits 7:0 for bytes, all 16 bits for words, low byte at the lower address) to the destination without reading memory, and leaves the source index unchanged.
- R5: After each element, every index the operation used steps by 1 for bytes or 2 for words. It is incremented when `dir_i`=0 and decremented when `dir_i`=1, with 16-bit wrap.
- R6: With any repeat mode (rep code 1, 2 or 3) and a start count of zero, no memory access is made, `done` still pulses, and the count and indices keep their loaded values.
- R7: In a repeat mode the count drops by one per element and the loop ends when it reaches zero. With rep code 0, exactly one element is processed and the count is left unchanged.
- R8: A scan (op code 3) compares the accumulator with the destination element, and a compare (op code 4) compares the source element with the destination element. Bytes compare bits 7:0 only. `zf` is 1 if the last comparison was equal and 0 if not.
- R9: For scan and compare, rep code 2 (repeat while equal) stops after the first unequal element and rep code 3 (repeat while not equal) stops after the first equal element. For the other operations both codes act as rep code 1.
- R10: With `irq` high when an element finishes and more remain, the sequencer raises `paused`, makes no memory access, and holds count and indices until `resume`. It then finishes with the same final result as an uninterrupted run.
- R11: At most one access is outstanding. While `mem_req` is high without `mem_ack`, the request, address and write enable hold steady.
- R12: After reset, `busy`, `paused`, `done`, `mem_req` and `zf` are 0.
- R13: `done` is a single-cycle pulse at the end of each operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| resume | input | 1 | Continue a paused operation |
| irq | input | 1 | Interrupt request, sampled between elements |
| op_i | input | 3 | 0 move, 1 load, 2 store, 3 scan, 4 compare |
| rep_i | input | 2 | 0 single, 1 repeat by count, 2 repeat while equal, 3 repeat while not equal |
| wide_i | input | 1 | 1 = word elements, 0 = byte elements |
| dir_i | input | 1 | 0 = increment indices, 1 = decrement |
| cx_i | input | 16 | Initial element count |
| si_i | input | 16 | Initial source index |
| di_i | input | 16 | Initial destination index |
| acc_i | input | 16 | Initial accumulator |
| ds_i | input | 16 | Source segment base |
| es_i | input | 16 | Destination segment base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | Access is a 16-bit word |
| mem_addr | output | 20 | Physical address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| busy | output | 1 | Operation in progress (including paused) |
| paused | output | 1 | Parked between elements |
| done | output | 1 | Operation finished (one cycle) |
| zf | output | 1 | Equality of the last comparison |
| cx_o | output | 16 | Current count |
| si_o | output | 16 | Current source index |
| di_o | output | 16 | Current destination index |
| acc_o | output | 16 | Current accumulator |

## Verification
The bench targets the corner cases where a sequencer tends to go wrong. A zero count with a repeat mode must give no accesses at all; a design that tests the count only after the first element would corrupt one location. Conditional repeats must stop on the right element, so a swapped equal/not-equal test or an off-by-one count decrement shows up as a wrong final count, index or flag. Byte operations must leave the upper accumulator byte alone and ignore the upper byte in comparisons. A segment near the top of the address space must wrap to a low physical address. An interrupted move is parked and then resumed. During the pause the bench watches for stray accesses and changed registers, and it confirms that the final copy and counts match an uninterrupted run.

// File: rtl/strop_pkg.sv
package strop_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_SCAN  = 3'd3,
        OP_CMP   = 3'd4
    } str_op_e;

    typedef enum logic [1:0] {
        RP_ONCE     = 2'd0,
        RP_COUNT    = 2'd1,
        RP_WHILE_EQ = 2'd2,
        RP_WHILE_NE = 2'd3
    } rep_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WRITE,
        ST_STEP,
        ST_PAUSE,
        ST_DONE
    } seq_state_e;

    function automatic logic op_uses_src(str_op_e op);
        return (op == OP_MOVE) || (op == OP_LOAD) || (op == OP_CMP);
    endfunction

    function automatic logic op_uses_dst(str_op_e op);
        return (op == OP_MOVE) || (op == OP_STORE) || (op == OP_SCAN) || (op == OP_CMP);
    endfunction

    function automatic logic op_compares(str_op_e op);
        return (op == OP_SCAN) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/strop_phys.sv
module strop_phys #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = OFF_W + SHIFT
) (
    input  logic [OFF_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa
);
    // Segment base scaled by the paragraph size plus the offset; carry out is dropped.
    assign pa = {seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off};
endmodule

// File: rtl/strop_step.sv
module strop_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] idx,
    input  logic         wide,
    input  logic         dir,
    output logic [W-1:0] nxt
);
    logic [W-1:0] delta;

    assign delta = wide ? W'(2) : W'(1);
    assign nxt   = dir ? (idx - delta) : (idx + delta);
endmodule

// File: rtl/strop_cmp.sv
module strop_cmp #(
    parameter int W = 16,
    localparam int HALF = W / 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         wide,
    output logic         eq
);
    assign eq = wide ? (a == b) : (a[HALF-1:0] == b[HALF-1:0]);
endmodule

// File: rtl/strop_ctrl.sv
module strop_ctrl
    import strop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       resume,
    input  logic       irq,
    input  logic       mem_ack,
    input  str_op_e    op,
    input  rep_mode_e  rep,
    input  logic       cx_zero,
    input  logic       cx_one,
    input  logic       elem_eq,
    output seq_state_e state,
    output logic       load_regs,
    output logic       cap_src,
    output logic       cap_dst,
    output logic       do_step,
    output logic       mem_req,
    output logic       mem_we,
    output logic       src_side,
    output logic       busy,
    output logic       paused,
    output logic       done
);
    seq_state_e nxt;
    logic       cond_stop;

    function automatic seq_state_e first_access(str_op_e o);
        seq_state_e s;
        unique case (o)
            OP_MOVE, OP_LOAD, OP_CMP: s = ST_RD_SRC;
            OP_STORE:                 s = ST_WRITE;
            OP_SCAN:                  s = ST_RD_DST;
            default:                  s = ST_DONE;
        endcase
        return s;
    endfunction

    assign cond_stop = op_compares(op) &&
                       (((rep == RP_WHILE_EQ) && !elem_eq) ||
                        ((rep == RP_WHILE_NE) &&  elem_eq));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_LAUNCH;
            ST_LAUNCH: nxt = ((rep != RP_ONCE) && cx_zero) ? ST_DONE : first_access(op);
            ST_RD_SRC: if (mem_ack) begin
                           if (op == OP_MOVE)     nxt = ST_WRITE;
                           else if (op == OP_CMP) nxt = ST_RD_DST;
                           else                   nxt = ST_STEP;
                       end
            ST_RD_DST: if (mem_ack) nxt = ST_STEP;
            ST_WRITE:  if (mem_ack) nxt = ST_STEP;
            ST_STEP: begin
                if ((rep == RP_ONCE) || cx_one || cond_stop) nxt = ST_DONE;
                else if (irq)                                nxt = ST_PAUSE;
                else                                         nxt = first_access(op);
            end
            ST_PAUSE:  if (resume) nxt = ST_LAUNCH;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_regs = 1'b0;
        cap_src   = 1'b0;
        cap_dst   = 1'b0;
        do_step   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        src_side  = 1'b0;
        busy      = 1'b1;
        paused    = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy      = 1'b0;
                load_regs = start;
            end
            ST_LAUNCH: ;
            ST_RD_SRC: begin
                mem_req  = 1'b1;
                src_side = 1'b1;
                cap_src  = mem_ack;
            end
            ST_RD_DST: begin
                mem_req = 1'b1;
                cap_dst = mem_ack;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_STEP:  do_step = 1'b1;
            ST_PAUSE: paused  = 1'b1;
            ST_DONE:  done    = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end
endmodule

// File: rtl/strop_engine.sv
module strop_engine
    import strop_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SEG_SHIFT = 4,
    localparam int ADDR_W   = DATA_W + SEG_SHIFT,
    localparam int BYTE_W   = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              resume,
    input  logic              irq,
    input  logic [2:0]        op_i,
    input  logic [1:0]        rep_i,
    input  logic              wide_i,
    input  logic              dir_i,
    input  logic [DATA_W-1:0] cx_i,
    input  logic [DATA_W-1:0] si_i,
    input  logic [DATA_W-1:0] di_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] ds_i,
    input  logic [DATA_W-1:0] es_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              paused,
    output logic              done,
    output logic              zf,
    output logic [DATA_W-1:0] cx_o,
    output logic [DATA_W-1:0] si_o,
    output logic [DATA_W-1:0] di_o,
    output logic [DATA_W-1:0] acc_o
);
    localparam int NSIDE = 2;   // index 0: destination side, 1: source side

    str_op_e           op_q;
    rep_mode_e         rep_q;
    logic              wide_q, dir_q;
    logic [DATA_W-1:0] cx_q, si_q, di_q, acc_q, ds_q, es_q;
    logic [DATA_W-1:0] src_q, dst_q;
    logic              zf_q;

    seq_state_e        state;
    logic              load_regs, cap_src, cap_dst, do_step, src_side;
    logic              elem_eq;

    logic [DATA_W-1:0] seg_v  [NSIDE];
    logic [DATA_W-1:0] idx_v  [NSIDE];
    logic [DATA_W-1:0] idx_nx [NSIDE];
    logic [ADDR_W-1:0] pa_v   [NSIDE];

    assign seg_v[0] = es_q;
    assign seg_v[1] = ds_q;
    assign idx_v[0] = di_q;
    assign idx_v[1] = si_q;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        strop_phys #(.OFF_W(DATA_W), .SHIFT(SEG_SHIFT)) u_phys (
            .seg (seg_v[g]),
            .off (idx_v[g]),
            .pa  (pa_v[g])
        );
        strop_step #(.W(DATA_W)) u_step (
            .idx  (idx_v[g]),
            .wide (wide_q),
            .dir  (dir_q),
            .nxt  (idx_nx[g])
        );
    end

    logic [DATA_W-1:0] cmp_lhs;
    assign cmp_lhs = (op_q == OP_SCAN) ? acc_q : src_q;

    strop_cmp #(.W(DATA_W)) u_cmp (
        .a    (cmp_lhs),
        .b    (dst_q),
        .wide (wide_q),
        .eq   (elem_eq)
    );

    strop_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .resume    (resume),
        .irq       (irq),
        .mem_ack   (mem_ack),
        .op        (op_q),
        .rep       (rep_q),
        .cx_zero   (cx_q == '0),
        .cx_one    (cx_q == DATA_W'(1)),
        .elem_eq   (elem_eq),
        .state     (state),
        .load_regs (load_regs),
        .cap_src   (cap_src),
        .cap_dst   (cap_dst),
        .do_step   (do_step),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .src_side  (src_side),
        .busy      (busy),
        .paused    (paused),
        .done      (done)
    );

    // Architectural and element registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_MOVE;
            rep_q  <= RP_ONCE;
            wide_q <= 1'b0;
            dir_q  <= 1'b0;
            cx_q   <= '0;
            si_q   <= '0;
            di_q   <= '0;
            acc_q  <= '0;
            ds_q   <= '0;
            es_q   <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            zf_q   <= 1'b0;
        end else begin
            if (load_regs) begin
                op_q   <= str_op_e'(op_i);
                rep_q  <= rep_mode_e'(rep_i);
                wide_q <= wide_i;
                dir_q  <= dir_i;
                cx_q   <= cx_i;
                si_q   <= si_i;
                di_q   <= di_i;
                acc_q  <= acc_i;
                ds_q   <= ds_i;
                es_q   <= es_i;
            end
            if (cap_src) src_q <= mem_rdata;
            if (cap_dst) dst_q <= mem_rdata;
            if (do_step) begin
                if (op_uses_src(op_q)) si_q <= idx_nx[1];
                if (op_uses_dst(op_q)) di_q <= idx_nx[0];
                if (rep_q != RP_ONCE)  cx_q <= cx_q - DATA_W'(1);
                if (op_q == OP_LOAD) begin
                    if (wide_q) acc_q <= src_q;
                    else        acc_q <= {acc_q[DATA_W-1:BYTE_W], src_q[BYTE_W-1:0]};
                end
                if (op_compares(op_q)) zf_q <= elem_eq;
            end
        end
    end

    logic [DATA_W-1:0] wr_val;
    assign wr_val    = (op_q == OP_STORE) ? acc_q : src_q;
    assign mem_wdata = wide_q ? wr_val : {{(DATA_W-BYTE_W){1'b0}}, wr_val[BYTE_W-1:0]};
    assign mem_addr  = src_side ? pa_v[1] : pa_v[0];
    assign mem_wide  = wide_q;

    assign zf    = zf_q;
    assign cx_o  = cx_q;
    assign si_o  = si_q;
    assign di_o  = di_q;
    assign acc_o = acc_q;
endmodule

// File: rtl/strop_engine_chk.sv
module strop_engine_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              paused,
    input logic              done,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] cx_o,
    input logic [DATA_W-1:0] si_o,
    input logic [DATA_W-1:0] di_o
);
    // A pending access keeps its request, address and direction.
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // No memory traffic while parked or idle.
    assert_quiet_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (paused || !busy) |-> !mem_req);

    // Resume state is frozen across the pause.
    assert_pause_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && $past(paused)) |-> ($stable(cx_o) && $stable(si_o) && $stable(di_o)));

    // Completion is one cycle wide.
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // During an operation the count only ever drops by one.
    assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$stable(cx_o)) |-> (cx_o == DATA_W'($past(cx_o) - DATA_W'(1))));

    // During an operation the source index moves by one element size.
    assert_src_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$stable(si_o)) |->
        ((si_o == DATA_W'($past(si_o) + DATA_W'(1))) || (si_o == DATA_W'($past(si_o) + DATA_W'(2))) ||
         (si_o == DATA_W'($past(si_o) - DATA_W'(1))) || (si_o == DATA_W'($past(si_o) - DATA_W'(2)))));

    // Same for the destination index.
    assert_dst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$stable(di_o)) |->
        ((di_o == DATA_W'($past(di_o) + DATA_W'(1))) || (di_o == DATA_W'($past(di_o) + DATA_W'(2))) ||
         (di_o == DATA_W'($past(di_o) - DATA_W'(1))) || (di_o == DATA_W'($past(di_o) - DATA_W'(2)))));
endmodule

bind strop_engine strop_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .paused   (paused),
    .done     (done),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .cx_o     (cx_o),
    .si_o     (si_o),
    .di_o     (di_o)
);

// File: tb/strop_engine_bench.sv
`timescale 1ns/1ps
module strop_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, resume = 1'b0, irq = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  rep_i = '0;
    logic        wide_i = 1'b0, dir_i = 1'b0;
    logic [15:0] cx_i = '0, si_i = '0, di_i = '0, acc_i = '0, ds_i = '0, es_i = '0;
    logic        mem_req, mem_we, mem_wide, mem_ack;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy, paused, done, zf;
    logic [15:0] cx_o, si_o, di_o, acc_o;

    always #2.5 clk = ~clk;   // 200 MHz

    strop_engine u_strop_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .irq(irq),
        .op_i(op_i), .rep_i(rep_i), .wide_i(wide_i), .dir_i(dir_i),
        .cx_i(cx_i), .si_i(si_i), .di_i(di_i), .acc_i(acc_i), .ds_i(ds_i), .es_i(es_i),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .paused(paused), .done(done), .zf(zf),
        .cx_o(cx_o), .si_o(si_o), .di_o(di_o), .acc_o(acc_o)
    );

    // Memory model: 4 KiB, little-endian words, configurable wait states
    logic [7:0]  mem [0:4095];
    int          lat_cfg = 0;
    int          wait_cnt = 0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [19:0] last_rd_addr = '0;
    logic        poke_en = 1'b0;
    logic [11:0] poke_a = '0;
    logic [7:0]  poke_d = '0;
    logic [11:0] ma;

    assign ma        = mem_addr[11:0];
    assign mem_ack   = mem_req && (wait_cnt >= lat_cfg);
    assign mem_rdata = {mem[ma + 12'd1], mem[ma]};

    always @(posedge clk) begin
        if (mem_req && !mem_ack) wait_cnt <= wait_cnt + 1;
        else                     wait_cnt <= 0;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                mem[ma] <= mem_wdata[7:0];
                if (mem_wide) mem[ma + 12'd1] <= mem_wdata[15:8];
            end else begin
                rd_cnt       <= rd_cnt + 1;
                last_rd_addr <= mem_addr;
            end
        end
        if (poke_en) mem[poke_a] <= poke_d;
    end

    int tests = 0, fails = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic launch(input logic [2:0] op, input logic [1:0] rep, input logic wide, input logic dir,
                          input logic [15:0] cx, input logic [15:0] si, input logic [15:0] di,
                          input logic [15:0] acc, input logic [15:0] ds, input logic [15:0] es);
        @(negedge clk);
        op_i = op; rep_i = rep; wide_i = wide; dir_i = dir;
        cx_i = cx; si_i = si; di_i = di; acc_i = acc; ds_i = ds; es_i = es;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait until done pulses or the sequencer parks; returns 1 if done was seen.
    task automatic wait_end(input string req, output logic saw_done);
        int n = 0;
        saw_done = 1'b0;
        while (!done && !paused && n < 2000) begin
            @(negedge clk);
            n++;
        end
        saw_done = done;
        if (n >= 2000) chk({req, " timeout"}, 32'd0, 32'd1);
    endtask

    task automatic t_reset;
        chk("R12 busy",   busy,    1'b0);
        chk("R12 req",    mem_req, 1'b0);
        chk("R12 zf",     zf,      1'b0);
        chk("R12 paused", paused,  1'b0);
        chk("R12 done",   done,    1'b0);
    endtask

    task automatic t_move_words;
        int r0, w0; logic d;
        for (int i = 0; i < 6; i++) poke(12'h104 + 12'(i), 8'hA0 + 8'(i));
        lat_cfg = 0; r0 = rd_cnt; w0 = wr_cnt;
        launch(3'd0, 2'd1, 1'b1, 1'b0, 16'd3, 16'h0004, 16'h0000, 16'h0, 16'h0010, 16'h0020);
        wait_end("R2", d);
        chk("R13 done seen", d, 1'b1);
        @(negedge clk);
        chk("R13 done single", done, 1'b0);
        for (int i = 0; i < 6; i++) chk("R2 R1 word copy", mem[12'h200 + 12'(i)], 8'hA0 + 8'(i));
        chk("R2 reads", rd_cnt - r0, 3);
        chk("R2 writes", wr_cnt - w0, 3);
        chk("R5 si word inc", si_o, 16'h000A);
        chk("R5 di word inc", di_o, 16'h0006);
        chk("R7 count end", cx_o, 16'd0);
    endtask

    task automatic t_move_bytes_dec;
        logic d;
        for (int i = 0; i < 4; i++) poke(12'h310 - 12'(i), 8'h30 + 8'(i));
        lat_cfg = 2;
        launch(3'd0, 2'd1, 1'b0, 1'b1, 16'd4, 16'h0010, 16'h0020, 16'h0, 16'h0030, 16'h0040);
        wait_end("R2", d);
        for (int i = 0; i < 4; i++) chk("R2 byte copy dec", mem[12'h420 - 12'(i)], 8'h30 + 8'(i));
        chk("R5 si byte dec", si_o, 16'h000C);
        chk("R5 di byte dec", di_o, 16'h001C);
        chk("R7 count end", cx_o, 16'd0);
        lat_cfg = 0;
    endtask

    task automatic t_load_wrap;
        int w0; logic d;
        poke(12'h010, 8'h5A);
        w0 = wr_cnt;
        launch(3'd1, 2'd0, 1'b0, 1'b1, 16'd7, 16'h0020, 16'h0000, 16'h1234, 16'hFFFF, 16'h0000);
        wait_end("R3", d);
        chk("R1 address wrap", last_rd_addr, 20'h00010);
        chk("R3 byte load keeps high", acc_o, 16'h125A);
        chk("R3 no write", wr_cnt - w0, 0);
        chk("R7 single keeps count", cx_o, 16'd7);
        chk("R5 si dec", si_o, 16'h001F);
    endtask

    task automatic t_store_words;
        int r0; logic d;
        r0 = rd_cnt;
        launch(3'd2, 2'd1, 1'b1, 1'b0, 16'd2, 16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 16'h0050);
        wait_end("R4", d);
        chk("R4 store b0", mem[12'h500], 8'hEF);
        chk("R4 store b1", mem[12'h501], 8'hBE);
        chk("R4 store b2", mem[12'h502], 8'hEF);
        chk("R4 store b3", mem[12'h503], 8'hBE);
        chk("R4 no read", rd_cnt - r0, 0);
        chk("R4 si untouched", si_o, 16'h1234);
        chk("R5 di", di_o, 16'h0004);
    endtask

    task automatic t_zero_count;
        int r0, w0; logic d;
        r0 = rd_cnt; w0 = wr_cnt;
        launch(3'd0, 2'd1, 1'b0, 1'b0, 16'd0, 16'h0055, 16'h0066, 16'h0, 16'h0000, 16'h0000);
        wait_end("R6", d);
        chk("R6 done", d, 1'b1);
        chk("R6 no access", (rd_cnt - r0) + (wr_cnt - w0), 0);
        chk("R6 si kept", si_o, 16'h0055);
        chk("R6 di kept", di_o, 16'h0066);
        chk("R6 cx kept", cx_o, 16'd0);
    endtask

    task automatic t_scan_eq;
        logic d;
        poke(12'h600, 8'h41); poke(12'h601, 8'h41); poke(12'h602, 8'h42); poke(12'h603, 8'h41);
        launch(3'd3, 2'd2, 1'b0, 1'b0, 16'd4, 16'h0000, 16'h0000, 16'h7741, 16'h0000, 16'h0060);
        wait_end("R9", d);
        chk("R9 while-eq stop count", cx_o, 16'd1);
        chk("R9 while-eq stop index", di_o, 16'h0003);
        chk("R8 zf mismatch", zf, 1'b0);
    endtask

    task automatic t_scan_ne;
        logic d;
        poke(12'h700, 8'h10); poke(12'h701, 8'h20); poke(12'h702, 8'h33); poke(12'h703, 8'h44);
        launch(3'd3, 2'd3, 1'b0, 1'b0, 16'd4, 16'h0000, 16'h0000, 16'h0033, 16'h0000, 16'h0070);
        wait_end("R9", d);
        chk("R9 while-ne stop count", cx_o, 16'd1);
        chk("R9 while-ne stop index", di_o, 16'h0003);
        chk("R8 zf match", zf, 1'b1);
    endtask

    task automatic t_cmp;
        int r0; logic d;
        poke(12'h800, 8'h11); poke(12'h801, 8'h11); poke(12'h802, 8'h22); poke(12'h803, 8'h22);
        poke(12'h900, 8'h11); poke(12'h901, 8'h11); poke(12'h902, 8'h22); poke(12'h903, 8'h22);
        r0 = rd_cnt;
        launch(3'd4, 2'd2, 1'b1, 1'b0, 16'd2, 16'h0000, 16'h0000, 16'h0, 16'h0080, 16'h0090);
        wait_end("R8", d);
        chk("R8 cmp words equal zf", zf, 1'b1);
        chk("R9 runs to count end", cx_o, 16'd0);
        chk("R8 cmp reads", rd_cnt - r0, 4);
        chk("R5 si", si_o, 16'h0004);
        // Single unequal byte compare: 0x11 at 0x800 vs 0x22 at 0x902
        launch(3'd4, 2'd0, 1'b0, 1'b0, 16'd9, 16'h0000, 16'h0002, 16'h0, 16'h0080, 16'h0090);
        wait_end("R8", d);
        chk("R8 cmp unequal zf", zf, 1'b0);
        chk("R7 single keeps count", cx_o, 16'd9);
        chk("R5 di", di_o, 16'h0003);
    endtask

    task automatic t_irq;
        int r0, w0, r1, w1; logic d;
        for (int i = 0; i < 3; i++) poke(12'hA00 + 12'(i), 8'hC0 + 8'(i));
        r0 = rd_cnt; w0 = wr_cnt;
        irq = 1'b1;
        launch(3'd0, 2'd1, 1'b0, 1'b0, 16'd3, 16'h0000, 16'h0000, 16'h0, 16'h00A0, 16'h00B0);
        wait_end("R10", d);
        chk("R10 parked", paused, 1'b1);
        chk("R10 resume cx", cx_o, 16'd2);
        chk("R10 resume si", si_o, 16'h0001);
        chk("R10 resume di", di_o, 16'h0001);
        r1 = rd_cnt; w1 = wr_cnt;
        repeat (6) @(negedge clk);
        chk("R10 no access while parked", (rd_cnt - r1) + (wr_cnt - w1), 0);
        chk("R10 cx held", cx_o, 16'd2);
        irq = 1'b0;
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        wait_end("R10", d);
        chk("R10 finished", d, 1'b1);
        for (int i = 0; i < 3; i++) chk("R10 copy after resume", mem[12'hB00 + 12'(i)], 8'hC0 + 8'(i));
        chk("R10 total reads", rd_cnt - r0, 3);
        chk("R10 total writes", wr_cnt - w0, 3);
        chk("R10 final cx", cx_o, 16'd0);
        chk("R10 final si", si_o, 16'h0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_move_words();
        t_move_bytes_dec();
        t_load_wrap();
        t_store_words();
        t_zero_count();
        t_scan_eq();
        t_scan_ne();
        t_cmp();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule